// File: doc/BRIEF.md
# Processor status and interrupt-acceptance unit

This unit holds the status word of a small processor core, the two banked 16-bit stack pointers and the 20-bit base of the interrupt vector table. Each cycle it decides whether a software interrupt or a maskable hardware request is taken. When one is taken, the unit raises a one-cycle acknowledge, presents the vector fetch address and a copy of the status word as it stood before the acceptance, and adjusts the status word itself. The surrounding core pushes that copy and fetches the vector. The unit does not do either.

The status word also takes whole-word writes from the core and condition-code updates from the arithmetic unit. The stack-select flag steers stack-pointer reads and writes to the interrupt or user pointer. The bank-select flag is driven out to the register file.

Top module: `psw_irq_unit`

## Requirements
- R1: After reset the status word, both stack pointers, the table base, the vector output, the snapshot output and the acknowledge are all 0.
- R2: A hardware request is taken only when the enable flag (bit 6) is 1 and the request priority is strictly greater than the level field (bits 14:12). A taken interrupt of either kind raises `ack` for exactly the cycle after the one in which it was presented.
- R3: Taking a hardware request clears the enable flag and the stack-select flag (bit 7), and loads the level field with the request priority, all in the same edge.
- R4: A software interrupt is always taken and clears the enable flag. It clears the stack-select flag only when its number is below 32, and it leaves the level field unchanged.
- R5: When a software interrupt and a hardware request arrive in the same cycle, the software interrupt is taken and the hardware request is not. A request that is still held is judged again on later cycles.
- R6: With `ack` high, `vec_addr` equals the table base plus 4 times the taken interrupt number, modulo 2^20. The base used is the one held before that edge.
- R7: With `ack` high, `flags_snap` equals the status word as it stood just before the acceptance edge.
- R8: A status-word write loads the layout carry=0, debug=1, zero=2, sign=3, bank=4, overflow=5, enable=6, stack-select=7, level=14:12. Bits 8 to 11 and bit 15 always read 0.
- R9: An arithmetic update sets zero when the result is 0 and sign from the result's top bit, and loads carry and overflow from their inputs. No other bit changes. A status-word write beats an arithmetic update in the same cycle. In an acceptance cycle, both the write and the update are ignored.
- R10: Stack-select 0 makes the interrupt stack pointer active, and 1 makes the user stack pointer active. `sp_rdata` shows the active pointer, and a write goes to the pointer active before the edge.
- R11: `bank_sel` follows the bank-select flag (bit 4).
- R12: A table-base write loads the 20-bit base, and later vector addresses use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Maskable hardware request |
| irq_prio | input | 3 | Priority of the hardware request |
| irq_num | input | 6 | Vector number of the hardware request |
| swi_req | input | 1 | Software interrupt being executed |
| swi_num | input | 6 | Software interrupt number |
| flg_we | input | 1 | Status-word write strobe |
| flg_wdata | input | 16 | Status-word write data |
| alu_we | input | 1 | Arithmetic condition update strobe |
| alu_res | input | 16 | Arithmetic result |
| alu_c | input | 1 | Carry, borrow or shift-out |
| alu_o | input | 1 | Signed overflow |
| sp_we | input | 1 | Active stack-pointer write strobe |
| sp_wdata | input | 16 | Stack-pointer write data |
| tb_we | input | 1 | Table-base write strobe |
| tb_wdata | input | 20 | Table-base write data |
| ack | output | 1 | Interrupt taken, one cycle |
| vec_addr | output | 20 | Vector fetch address |
| flags_snap | output | 16 | Status word before the acceptance |
| sp_rdata | output | 16 | Active stack pointer |
| bank_sel | output | 1 | Register bank select |
| flags_q | output | 16 | Current status word |

## Verification
Two kinds of overlap can occur in one cycle, and both are forced on purpose. The first is a software interrupt alongside a hardware request that would qualify on its own. The second is an acceptance alongside a status-word write or an arithmetic update. The directed cases raise these pairs together. A long mixed run then raises them at random. A behavioural model in the bench applies the precedence stated in R5 and R9, and each cycle it compares its level field, enable and stack-select flags, vector address and snapshot with the outputs of the unit.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
   localparam int FLAG_W = 16;
   localparam int BIT_C  = 0;
   localparam int BIT_D  = 1;
   localparam int BIT_Z  = 2;
   localparam int BIT_S  = 3;
   localparam int BIT_B  = 4;
   localparam int BIT_O  = 5;
   localparam int BIT_I  = 6;
   localparam int BIT_U  = 7;
   localparam int IPL_LO = 12;
   localparam int IPL_W  = 3;
   localparam logic [FLAG_W-1:0] FLAG_MASK = 16'h70FF;

   typedef struct packed {
      logic             valid;
      logic             hw;
      logic             clr_u;
      logic [IPL_W-1:0] prio;
   } accept_t;
endpackage

// File: rtl/psw_arbiter.sv
`timescale 1ns/1ps
module psw_arbiter
   import psw_pkg::*;
#(
   parameter int NUM_W      = 6,
   parameter int SW_U_LIMIT = 32
) (
   input  logic             irq_req,
   input  logic [IPL_W-1:0] irq_prio,
   input  logic [NUM_W-1:0] irq_num,
   input  logic             swi_req,
   input  logic [NUM_W-1:0] swi_num,
   input  logic             flag_i,
   input  logic [IPL_W-1:0] ipl,
   output accept_t          acc,
   output logic [NUM_W-1:0] acc_num
);
   localparam int NUM_SPAN = 1 << NUM_W;

   logic hw_ok;
   logic low_sw;

   // Numbers below the limit force the interrupt stack.
   generate
      if (SW_U_LIMIT >= NUM_SPAN) begin : g_all_low
         assign low_sw = 1'b1;
      end else if (SW_U_LIMIT <= 0) begin : g_none_low
         assign low_sw = 1'b0;
      end else begin : g_cmp_low
         assign low_sw = (swi_num < NUM_W'(SW_U_LIMIT));
      end
   endgenerate

   always_comb begin
      hw_ok     = irq_req && flag_i && (irq_prio > ipl);
      acc.valid = swi_req || hw_ok;
      acc.hw    = hw_ok && !swi_req;
      acc.prio  = irq_prio;
      acc.clr_u = (hw_ok && !swi_req) || (swi_req && low_sw);
      acc_num   = swi_req ? swi_num : irq_num;
   end
endmodule

// File: rtl/psw_flag_reg.sv
`timescale 1ns/1ps
module psw_flag_reg
   import psw_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  accept_t           acc,
   input  logic              flg_we,
   input  logic [FLAG_W-1:0] flg_wdata,
   input  logic              alu_we,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_c,
   input  logic              alu_o,
   output logic [FLAG_W-1:0] flags_q,
   output logic [FLAG_W-1:0] flags_snap
);
   logic [FLAG_W-1:0] nxt;

   always_comb begin
      nxt = flags_q;
      if (acc.valid) begin
         nxt[BIT_I] = 1'b0;
         if (acc.clr_u) nxt[BIT_U] = 1'b0;
         if (acc.hw)    nxt[IPL_LO +: IPL_W] = acc.prio;
      end else if (flg_we) begin
         nxt = flg_wdata & FLAG_MASK;
      end else if (alu_we) begin
         nxt[BIT_C] = alu_c;
         nxt[BIT_Z] = (alu_res == '0);
         nxt[BIT_S] = alu_res[DATA_W-1];
         nxt[BIT_O] = alu_o;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q    <= '0;
         flags_snap <= '0;
      end else begin
         flags_q <= nxt;
         if (acc.valid) flags_snap <= flags_q;
      end
   end
endmodule

// File: rtl/psw_sp_bank.sv
`timescale 1ns/1ps
module psw_sp_bank #(
   parameter int SP_W  = 16,
   parameter int BANKS = 2,
   localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic            we,
   input  logic [SP_W-1:0] wdata,
   output logic [SP_W-1:0] rdata
);
   logic [SP_W-1:0] sp_q [BANKS];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              sp_q[b] <= '0;
            else if (we && (int'(sel) == b))         sp_q[b] <= wdata;
         end
      end
   endgenerate

   assign rdata = sp_q[sel];
endmodule

// File: rtl/psw_vector_gen.sv
`timescale 1ns/1ps
module psw_vector_gen #(
   parameter int TB_W      = 20,
   parameter int NUM_W     = 6,
   parameter int VEC_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tb_we,
   input  logic [TB_W-1:0]  tb_wdata,
   input  logic             acc_valid,
   input  logic [NUM_W-1:0] acc_num,
   output logic             ack,
   output logic [TB_W-1:0]  vec_addr,
   output logic [TB_W-1:0]  tbase_q
);
   logic [TB_W-1:0] offset;
   assign offset = TB_W'(acc_num) << VEC_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbase_q  <= '0;
         vec_addr <= '0;
         ack      <= 1'b0;
      end else begin
         ack <= acc_valid;
         if (acc_valid) vec_addr <= tbase_q + offset;
         if (tb_we)     tbase_q  <= tb_wdata;
      end
   end
endmodule

// File: rtl/psw_irq_unit.sv
`timescale 1ns/1ps
module psw_irq_unit
   import psw_pkg::*;
#(
   parameter int SP_W       = 16,
   parameter int TB_W       = 20,
   parameter int NUM_W      = 6,
   parameter int DATA_W     = 16,
   parameter int VEC_SHIFT  = 2,
   parameter int SW_U_LIMIT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [IPL_W-1:0]  irq_prio,
   input  logic [NUM_W-1:0]  irq_num,
   input  logic              swi_req,
   input  logic [NUM_W-1:0]  swi_num,
   input  logic              flg_we,
   input  logic [FLAG_W-1:0] flg_wdata,
   input  logic              alu_we,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_c,
   input  logic              alu_o,
   input  logic              sp_we,
   input  logic [SP_W-1:0]   sp_wdata,
   input  logic              tb_we,
   input  logic [TB_W-1:0]   tb_wdata,
   output logic              ack,
   output logic [TB_W-1:0]   vec_addr,
   output logic [FLAG_W-1:0] flags_snap,
   output logic [SP_W-1:0]   sp_rdata,
   output logic              bank_sel,
   output logic [FLAG_W-1:0] flags_q
);
   generate
      if (SP_W < 1)                    begin : g_bad_sp   $error("SP_W must be positive");            end
      if (DATA_W < 1)                  begin : g_bad_dat  $error("DATA_W must be positive");          end
      if (NUM_W < 1)                   begin : g_bad_num  $error("NUM_W must be positive");           end
      if (TB_W < NUM_W + VEC_SHIFT)    begin : g_bad_tb   $error("TB_W too narrow for vector offset"); end
   endgenerate

   accept_t          acc;
   logic [NUM_W-1:0] acc_num;
   logic [TB_W-1:0]  tbase_q;

   psw_arbiter #(.NUM_W(NUM_W), .SW_U_LIMIT(SW_U_LIMIT)) u_arb (
      .irq_req  (irq_req),
      .irq_prio (irq_prio),
      .irq_num  (irq_num),
      .swi_req  (swi_req),
      .swi_num  (swi_num),
      .flag_i   (flags_q[BIT_I]),
      .ipl      (flags_q[IPL_LO +: IPL_W]),
      .acc      (acc),
      .acc_num  (acc_num)
   );

   psw_flag_reg #(.DATA_W(DATA_W)) u_flg (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .flg_we     (flg_we),
      .flg_wdata  (flg_wdata),
      .alu_we     (alu_we),
      .alu_res    (alu_res),
      .alu_c      (alu_c),
      .alu_o      (alu_o),
      .flags_q    (flags_q),
      .flags_snap (flags_snap)
   );

   psw_sp_bank #(.SP_W(SP_W), .BANKS(2)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (flags_q[BIT_U]),
      .we    (sp_we),
      .wdata (sp_wdata),
      .rdata (sp_rdata)
   );

   psw_vector_gen #(.TB_W(TB_W), .NUM_W(NUM_W), .VEC_SHIFT(VEC_SHIFT)) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .tb_we     (tb_we),
      .tb_wdata  (tb_wdata),
      .acc_valid (acc.valid),
      .acc_num   (acc_num),
      .ack       (ack),
      .vec_addr  (vec_addr),
      .tbase_q   (tbase_q)
   );

   assign bank_sel = flags_q[BIT_B];
endmodule

// File: rtl/psw_irq_unit_chk.sv
`timescale 1ns/1ps
module psw_irq_unit_chk #(
   parameter int TB_W       = 20,
   parameter int NUM_W      = 6,
   parameter int VEC_SHIFT  = 2,
   parameter int SW_U_LIMIT = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic [2:0]       irq_prio,
   input logic [NUM_W-1:0] irq_num,
   input logic             swi_req,
   input logic [NUM_W-1:0] swi_num,
   input logic             ack,
   input logic [TB_W-1:0]  vec_addr,
   input logic [TB_W-1:0]  tbase_q,
   input logic [15:0]      flags_q,
   input logic [15:0]      flags_snap
);
   logic [2:0]       ipl;
   logic             hw_qual;
   logic [TB_W-1:0]  prev_tb;
   logic [NUM_W-1:0] prev_num;

   assign ipl     = flags_q[14:12];
   assign hw_qual = irq_req && flags_q[6] && (irq_prio > ipl);

   always_ff @(posedge clk) begin
      prev_tb  <= tbase_q;
      prev_num <= swi_req ? swi_num : irq_num;
   end

   assert_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!swi_req && !hw_qual) |=> !ack);

   assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_req || hw_qual) |=> ack);

   assert_hw_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_qual && !swi_req) |=> (ipl == $past(irq_prio)) && !flags_q[6] && !flags_q[7]);

   assert_sw_keep_u_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_req && (int'(swi_num) >= SW_U_LIMIT)) |=> (flags_q[7] == $past(flags_q[7])) && !flags_q[6]);

   assert_sw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_req && irq_req) |=> $stable(ipl));

   assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (vec_addr == prev_tb + (TB_W'(prev_num) << VEC_SHIFT)));

   assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (flags_snap == $past(flags_q)));

   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[11:8] == 4'd0) && !flags_q[15]);
endmodule

bind psw_irq_unit psw_irq_unit_chk #(
   .TB_W(TB_W), .NUM_W(NUM_W), .VEC_SHIFT(VEC_SHIFT), .SW_U_LIMIT(SW_U_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_req    (irq_req),
   .irq_prio   (irq_prio),
   .irq_num    (irq_num),
   .swi_req    (swi_req),
   .swi_num    (swi_num),
   .ack        (ack),
   .vec_addr   (vec_addr),
   .tbase_q    (tbase_q),
   .flags_q    (flags_q),
   .flags_snap (flags_snap)
);

// File: tb/psw_irq_unit_test.sv
`timescale 1ns/1ps
module psw_irq_unit_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        irq_req = 0;
   logic [2:0]  irq_prio = 0;
   logic [5:0]  irq_num = 0;
   logic        swi_req = 0;
   logic [5:0]  swi_num = 0;
   logic        flg_we = 0;
   logic [15:0] flg_wdata = 0;
   logic        alu_we = 0;
   logic [15:0] alu_res = 0;
   logic        alu_c = 0, alu_o = 0;
   logic        sp_we = 0;
   logic [15:0] sp_wdata = 0;
   logic        tb_we = 0;
   logic [19:0] tb_wdata = 0;
   logic        ack;
   logic [19:0] vec_addr;
   logic [15:0] flags_snap, sp_rdata, flags_q;
   logic        bank_sel;

   psw_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio), .irq_num(irq_num),
      .swi_req(swi_req), .swi_num(swi_num), .flg_we(flg_we), .flg_wdata(flg_wdata),
      .alu_we(alu_we), .alu_res(alu_res), .alu_c(alu_c), .alu_o(alu_o),
      .sp_we(sp_we), .sp_wdata(sp_wdata), .tb_we(tb_we), .tb_wdata(tb_wdata),
      .ack(ack), .vec_addr(vec_addr), .flags_snap(flags_snap), .sp_rdata(sp_rdata),
      .bank_sel(bank_sel), .flags_q(flags_q)
   );

   int total = 0;
   int bad   = 0;
   string phase = "R1";

   // Behavioural reference: one variable per flag.
   int m_c, m_d, m_z, m_s, m_b, m_o, m_i, m_u, m_ipl;
   int m_isp, m_usp, m_tb, m_ack, m_vec, m_snap;

   function automatic int m_word();
      return m_c + 2*m_d + 4*m_z + 8*m_s + 16*m_b + 32*m_o + 64*m_i + 128*m_u + 4096*m_ipl;
   endfunction

   task automatic m_reset();
      m_c = 0; m_d = 0; m_z = 0; m_s = 0; m_b = 0; m_o = 0; m_i = 0; m_u = 0; m_ipl = 0;
      m_isp = 0; m_usp = 0; m_tb = 0; m_ack = 0; m_vec = 0; m_snap = 0;
   endtask

   task automatic m_step();
      int  num, old_word, old_tb, old_u;
      bit  sw, hw;
      old_word = m_word();
      old_tb   = m_tb;
      old_u    = m_u;
      sw  = swi_req;
      hw  = irq_req && (m_i == 1) && (int'(irq_prio) > m_ipl) && !sw;
      num = sw ? int'(swi_num) : int'(irq_num);
      m_ack = (sw || hw) ? 1 : 0;
      if (sw || hw) begin
         m_vec  = (old_tb + num * 4) % (1 << 20);
         m_snap = old_word;
         m_i = 0;
         if (hw) begin m_u = 0; m_ipl = int'(irq_prio); end
         if (sw && num < 32) m_u = 0;
      end else if (flg_we) begin
         m_c = flg_wdata[0]; m_d = flg_wdata[1]; m_z = flg_wdata[2]; m_s = flg_wdata[3];
         m_b = flg_wdata[4]; m_o = flg_wdata[5]; m_i = flg_wdata[6]; m_u = flg_wdata[7];
         m_ipl = int'(flg_wdata[14:12]);
      end else if (alu_we) begin
         m_c = alu_c;
         m_o = alu_o;
         m_z = (alu_res == 16'd0) ? 1 : 0;
         m_s = alu_res[15];
      end
      if (sp_we) begin
         if (old_u == 1) m_usp = int'(sp_wdata);
         else            m_isp = int'(sp_wdata);
      end
      if (tb_we) m_tb = int'(tb_wdata);
   endtask

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("flags", int'(flags_q), m_word());
      chk("sp", int'(sp_rdata), (m_u == 1) ? m_usp : m_isp);
      chk("bank", int'(bank_sel), m_b);
      chk("ack", int'(ack), m_ack);
      chk("vec", int'(vec_addr), m_vec);
      chk("snap", int'(flags_snap), m_snap);
   endtask

   task automatic tick();
      @(posedge clk);
      if (!rst_n) m_reset();
      else        m_step();
      #1;
      compare_all();
   endtask

   task automatic idle();
      irq_req = 0; swi_req = 0; flg_we = 0; alu_we = 0; sp_we = 0; tb_we = 0;
   endtask

   task automatic do_flag(logic [15:0] d);
      flg_we = 1; flg_wdata = d; tick(); idle();
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #4000000;
      total++; bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      summary();
      $finish;
   end

   initial begin
      m_reset();
      // R1: reset state
      phase = "R1";
      tick(); tick();
      #2 rst_n = 1'b1;
      chk("reset flags", int'(flags_q), 0);
      chk("reset ack", int'(ack), 0);
      tick();

      // R8: layout and reserved bits
      phase = "R8";
      do_flag(16'hFFFF);
      chk("masked word", int'(flags_q), 32'h70FF);
      do_flag(16'h0F00);
      chk("reserved only", int'(flags_q), 0);

      // R11: bank flag
      phase = "R11";
      do_flag(16'h0010);
      chk("bank high", int'(bank_sel), 1);
      do_flag(16'h0000);

      // R10: banked stack pointers
      phase = "R10";
      sp_we = 1; sp_wdata = 16'h1234; tick(); idle();
      do_flag(16'h0080);
      sp_we = 1; sp_wdata = 16'hBEEF; tick(); idle();
      chk("user sp", int'(sp_rdata), 32'hBEEF);
      do_flag(16'h0000);
      chk("interrupt sp", int'(sp_rdata), 32'h1234);

      // R12: table base
      phase = "R12";
      tb_we = 1; tb_wdata = 20'h40000; tick(); idle();
      swi_req = 1; swi_num = 6'd3; tick(); idle();
      chk("vec from new base", int'(vec_addr), 32'h4000C);

      // R2: strict priority compare and enable gate
      phase = "R2";
      do_flag(16'h30C0);              // I=1, U=1, level 3
      irq_req = 1; irq_prio = 3'd3; irq_num = 6'd9; tick();
      chk("equal prio refused", int'(ack), 0);
      irq_prio = 3'd2; tick();
      chk("lower prio refused", int'(ack), 0);
      irq_prio = 3'd4; tick(); idle();
      chk("higher prio taken", int'(ack), 1);
      tick();
      chk("ack one cycle", int'(ack), 0);

      // R3: effects of a hardware acceptance
      phase = "R3";
      chk("level loaded", int'(flags_q[14:12]), 4);
      chk("enable cleared", int'(flags_q[6]), 0);
      chk("stack select cleared", int'(flags_q[7]), 0);
      irq_req = 1; irq_prio = 3'd7; tick(); idle();
      chk("disabled refused", int'(ack), 0);

      // R4: software interrupt numbers
      phase = "R4";
      do_flag(16'h20C0);
      swi_req = 1; swi_num = 6'd40; tick(); idle();
      chk("high number keeps U", int'(flags_q[7]), 1);
      chk("level kept", int'(flags_q[14:12]), 2);
      swi_req = 1; swi_num = 6'd31; tick(); idle();
      chk("low number clears U", int'(flags_q[7]), 0);

      // R5: software and hardware in one cycle
      phase = "R5";
      do_flag(16'h10C0);
      swi_req = 1; swi_num = 6'd50; irq_req = 1; irq_prio = 3'd6; irq_num = 6'd2; tick();
      swi_req = 0;
      chk("level untouched", int'(flags_q[14:12]), 1);
      do_flag(16'h10C0);
      irq_req = 1; tick(); idle();
      chk("held request later taken", int'(flags_q[14:12]), 6);

      // R6: wraparound of vector address
      phase = "R6";
      tb_we = 1; tb_wdata = 20'hFFFF0; tick(); idle();
      swi_req = 1; swi_num = 6'd63; tick(); idle();
      chk("wrapped vector", int'(vec_addr), 32'h000EC);

      // R9: arithmetic updates and precedence
      phase = "R9";
      do_flag(16'h0012);
      alu_we = 1; alu_res = 16'h0000; alu_c = 1; alu_o = 0; tick();
      alu_res = 16'h8001; alu_c = 0; alu_o = 1; tick();
      flg_we = 1; flg_wdata = 16'h0001; tick(); idle();
      chk("write beats update", int'(flags_q), 1);
      do_flag(16'h00C0);
      swi_req = 1; swi_num = 6'd33; flg_we = 1; flg_wdata = 16'h00FF;
      alu_we = 1; alu_res = 0; tick(); idle();
      chk("accept ignores write", int'(flags_q), 32'h0080);

      // R7: mixed random traffic
      phase = "R7";
      for (int n = 0; n < 600; n++) begin
         irq_req   = ($urandom % 3) == 0;
         irq_prio  = 3'($urandom);
         irq_num   = 6'($urandom);
         swi_req   = ($urandom % 9) == 0;
         swi_num   = 6'($urandom);
         flg_we    = ($urandom % 5) == 0;
         flg_wdata = 16'($urandom) | 16'h0040;
         alu_we    = ($urandom % 3) == 0;
         alu_res   = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
         alu_c     = 1'($urandom);
         alu_o     = 1'($urandom);
         sp_we     = ($urandom % 4) == 0;
         sp_wdata  = 16'($urandom);
         tb_we     = ($urandom % 20) == 0;
         tb_wdata  = 20'($urandom);
         tick();
      end
      idle();
      tick();

      summary();
      $finish;
   end
endmodule